// File: doc/BRIEF.md
# Real-Time Clock Prescaler and Subsecond Counter

This block turns a slow reference clock into the timebases of a real-time clock. A first programmable divider creates a one-cycle "fast tick" enable. On every fast tick a subsecond down-counter moves by one. What that counter does depends on a two-bit mode selection. In calendar mode it is a reload counter that produces a one-second tick. In binary and mixed modes it is a free-running 32-bit down-counter.

Every part of the block runs on the single input clock. Ticks are one-cycle enables, not derived clocks. The divider values and the mode are taken from the inputs only while the `init_en` input is high. During that window all counting stops. When `init_en` falls, the counters start from their reload values. Outside that window, changes on the configuration inputs have no effect.

Top module: `rtc_prescaler_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `fast_tick` and `sec_tick` are 0 and `subsec_count` is 255. The configuration resets to: first divider value 127, second divider value 255, calendar mode.
- R2: Let A be the first divider value. Out of init, `fast_tick` is a one-cycle pulse that comes every A+1 clock cycles. The first pulse is visible A+1 cycles after init ends. With A = 0 it is high on every cycle.
- R3: In calendar mode (mode code 00), `subsec_count` falls by one on each fast tick. The tick after it reads 0 reloads it to the second divider value S, zero-extended to 32 bits. Between ticks the counter holds its value.
- R4: In calendar mode, `sec_tick` is a one-cycle pulse in the same cycle as the fast tick that reloads the counter from 0. Its period is (S+1)×(A+1) cycles.
- R5: In binary mode (mode code 01), `subsec_count` starts at 0xFFFFFFFF. It falls by one on each fast tick and wraps from 0 to 0xFFFFFFFF. S has no effect, and `sec_tick` stays 0.
- R6: In mixed mode (mode codes 10 and 11), `subsec_count` counts as in R5. `sec_tick` pulses with the fast tick that leaves a count whose low MIX_SEC_BITS bits were all zero.
- R7: While `init_en` is high, `fast_tick` and `sec_tick` stay 0 and the counters do not run. Values on `mode_in`, `async_div_in` and `sync_div_in` while `init_en` is low have no effect.
- R8: On the first cycle after init, `subsec_count` equals its reload value. In calendar mode that is S; otherwise it is 0xFFFFFFFF.
- R9: With the reset configuration, the first `sec_tick` appears 32768 cycles after reset is released, and the first `fast_tick` appears 128 cycles after reset is released. This is exactly 1 Hz from a 32.768 kHz clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all logic is synchronous to it |
| rst | input | 1 | Synchronous active-high reset |
| init_en | input | 1 | High: sample configuration and hold counters |
| mode_in | input | 2 | Mode: 00 calendar, 01 binary, 1x mixed |
| async_div_in | input | 7 | First divider value A (divide by A+1) |
| sync_div_in | input | 15 | Second divider value S (divide by S+1) |
| fast_tick | output | 1 | One-cycle first-stage tick |
| sec_tick | output | 1 | One-cycle second tick |
| subsec_count | output | 32 | Subsecond down-counter value |

## Verification
The hardest case to reach is the cycle where the counter reload, the fast tick and the second tick all fall together. This is most demanding with the smallest dividers, where every cycle is a tick. The bench sweeps small first and second divider values across all four mode codes. For every cycle it computes the expected counter value and tick flags from the number of cycles since init ended. It also scrambles the configuration inputs on every running cycle, so any leak of an unsampled value shows up. The 32-bit wrap in the free-running modes is too far away to reach from the ports. A checker property that covers every decrement step covers it instead.

// File: rtl/rtc_presc_pkg.sv
package rtc_presc_pkg;

  typedef enum logic [1:0] {
    MODE_CAL   = 2'b00,
    MODE_BIN   = 2'b01,
    MODE_MIX_A = 2'b10,
    MODE_MIX_B = 2'b11
  } ss_mode_e;

  function automatic logic mode_is_cal(input logic [1:0] m);
    return m == MODE_CAL;
  endfunction

  function automatic logic mode_is_bin(input logic [1:0] m);
    return m == MODE_BIN;
  endfunction

endpackage

// File: rtl/rtc_presc_cfg.sv
module rtc_presc_cfg #(
  parameter int AW    = 7,
  parameter int SW    = 15,
  parameter int A_RST = 127,
  parameter int S_RST = 255
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_en,
  input  logic [1:0]    mode_in,
  input  logic [AW-1:0] async_in,
  input  logic [SW-1:0] sync_in,
  output logic [1:0]    cfg_mode,
  output logic [AW-1:0] cfg_async,
  output logic [SW-1:0] cfg_sync
);
  import rtc_presc_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_mode  <= MODE_CAL;
      cfg_async <= AW'(A_RST);
      cfg_sync  <= SW'(S_RST);
    end else if (init_en) begin
      cfg_mode  <= mode_in;
      cfg_async <= async_in;
      cfg_sync  <= sync_in;
    end
  end

endmodule

// File: rtl/rtc_presc_async.sv
module rtc_presc_async #(
  parameter int AW    = 7,
  parameter int A_RST = 127
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_en,
  input  logic [AW-1:0] load_val,
  input  logic [AW-1:0] reload_val,
  output logic          tick_en,
  output logic          fast_tick
);
  logic [AW-1:0] acnt;

  assign tick_en = !init_en && (acnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      acnt      <= AW'(A_RST);
      fast_tick <= 1'b0;
    end else if (init_en) begin
      acnt      <= load_val;
      fast_tick <= 1'b0;
    end else begin
      fast_tick <= tick_en;
      acnt      <= tick_en ? reload_val : acnt - 1'b1;
    end
  end

endmodule

// File: rtl/rtc_presc_subsec.sv
module rtc_presc_subsec #(
  parameter int SW    = 15,
  parameter int SSW   = 32,
  parameter int MB    = 8,
  parameter int S_RST = 255
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           init_en,
  input  logic           tick_en,
  input  logic [1:0]     load_mode,
  input  logic [SW-1:0]  load_sync,
  input  logic [1:0]     cfg_mode,
  input  logic [SW-1:0]  cfg_sync,
  output logic           sec_tick,
  output logic [SSW-1:0] subsec
);
  import rtc_presc_pkg::*;

  logic cal_now, bin_now, zero_hit, mix_hit;

  assign cal_now  = mode_is_cal(cfg_mode);
  assign bin_now  = mode_is_bin(cfg_mode);
  assign zero_hit = (subsec == '0);

  generate
    if (MB > 0) begin : g_mix
      assign mix_hit = (subsec[MB-1:0] == '0);
    end else begin : g_nomix
      assign mix_hit = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      subsec   <= SSW'(S_RST);
      sec_tick <= 1'b0;
    end else if (init_en) begin
      subsec   <= mode_is_cal(load_mode) ? SSW'(load_sync) : '1;
      sec_tick <= 1'b0;
    end else begin
      sec_tick <= tick_en && (cal_now ? zero_hit : (!bin_now && mix_hit));
      if (tick_en) begin
        subsec <= (cal_now && zero_hit) ? SSW'(cfg_sync) : subsec - 1'b1;
      end
    end
  end

endmodule

// File: rtl/rtc_prescaler_top.sv
module rtc_prescaler_top #(
  parameter int AW           = 7,
  parameter int SW           = 15,
  parameter int SSW          = 32,
  parameter int MIX_SEC_BITS = 8,
  parameter int A_RST        = 127,
  parameter int S_RST        = 255
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           init_en,
  input  logic [1:0]     mode_in,
  input  logic [AW-1:0]  async_div_in,
  input  logic [SW-1:0]  sync_div_in,
  output logic           fast_tick,
  output logic           sec_tick,
  output logic [SSW-1:0] subsec_count
);
  logic [1:0]    cfg_mode;
  logic [AW-1:0] cfg_async;
  logic [SW-1:0] cfg_sync;
  logic          tick_en;

  rtc_presc_cfg #(.AW(AW), .SW(SW), .A_RST(A_RST), .S_RST(S_RST)) u_cfg (
    .clk(clk), .rst(rst), .init_en(init_en), .mode_in(mode_in),
    .async_in(async_div_in), .sync_in(sync_div_in),
    .cfg_mode(cfg_mode), .cfg_async(cfg_async), .cfg_sync(cfg_sync)
  );

  rtc_presc_async #(.AW(AW), .A_RST(A_RST)) u_async (
    .clk(clk), .rst(rst), .init_en(init_en), .load_val(async_div_in),
    .reload_val(cfg_async), .tick_en(tick_en), .fast_tick(fast_tick)
  );

  rtc_presc_subsec #(.SW(SW), .SSW(SSW), .MB(MIX_SEC_BITS), .S_RST(S_RST)) u_ss (
    .clk(clk), .rst(rst), .init_en(init_en), .tick_en(tick_en),
    .load_mode(mode_in), .load_sync(sync_div_in),
    .cfg_mode(cfg_mode), .cfg_sync(cfg_sync),
    .sec_tick(sec_tick), .subsec(subsec_count)
  );

endmodule

// File: rtl/rtc_prescaler_chk.sv
module rtc_prescaler_chk #(
  parameter int SSW = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           init_en,
  input logic           fast_tick,
  input logic           sec_tick,
  input logic [SSW-1:0] subsec_count,
  input logic [1:0]     cfg_mode
);
  logic past_valid;

  always_ff @(posedge clk) begin
    if (rst) past_valid <= 1'b0;
    else     past_valid <= 1'b1;
  end

  // R7
  init_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    init_en |=> (!fast_tick && !sec_tick));

  // R4
  sec_on_fast_chk: assert property (@(posedge clk) disable iff (rst)
    sec_tick |-> fast_tick);

  // R5
  bin_no_sec_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'b01) |-> !sec_tick);

  // R3
  cal_step_chk: assert property (@(posedge clk) disable iff (rst)
    (past_valid && !$past(init_en) && fast_tick && cfg_mode == 2'b00 &&
     $past(subsec_count) != '0) |-> (subsec_count == $past(subsec_count) - 1'b1));

  // R4
  cal_reload_sec_chk: assert property (@(posedge clk) disable iff (rst)
    (past_valid && !$past(init_en) && fast_tick && cfg_mode == 2'b00 &&
     $past(subsec_count) == '0) |-> sec_tick);

  // R5
  free_step_chk: assert property (@(posedge clk) disable iff (rst)
    (past_valid && !$past(init_en) && fast_tick && cfg_mode != 2'b00)
    |-> (subsec_count == $past(subsec_count) - 1'b1));

  // R3
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    (past_valid && !$past(init_en) && !fast_tick) |-> $stable(subsec_count));

endmodule

bind rtc_prescaler_top rtc_prescaler_chk #(.SSW(SSW)) u_chk (
  .clk(clk), .rst(rst), .init_en(init_en), .fast_tick(fast_tick),
  .sec_tick(sec_tick), .subsec_count(subsec_count), .cfg_mode(cfg_mode)
);

// File: tb/sim_rtc_prescaler_top.sv
`timescale 1ns/1ps
module sim_rtc_prescaler_top;
  localparam int MB = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        init_en = 1'b0;
  logic [1:0]  mode_in = 2'b00;
  logic [6:0]  async_div_in = '0;
  logic [14:0] sync_div_in = '0;
  logic        fast_tick, sec_tick;
  logic [31:0] subsec_count;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_prescaler_top #(.MIX_SEC_BITS(MB)) u0 (
    .clk(clk), .rst(rst), .init_en(init_en), .mode_in(mode_in),
    .async_div_in(async_div_in), .sync_div_in(sync_div_in),
    .fast_tick(fast_tick), .sec_tick(sec_tick), .subsec_count(subsec_count)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Configure, hold init for a few cycles, then run and compare every cycle.
  task automatic run_cfg(input int a, input int s, input int m, input int ncyc);
    longint ld, f, exp_ss;
    bit ft, st;
    @(negedge clk);
    init_en = 1'b1; mode_in = 2'(m); async_div_in = 7'(a); sync_div_in = 15'(s);
    ld = (m == 0) ? longint'(s) : 64'hFFFF_FFFF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R7 init fast", fast_tick, 0);
      check("R7 init sec", sec_tick, 0);
      check("R7 init hold", subsec_count, ld);
    end
    init_en = 1'b0;
    for (int n = 1; n <= ncyc; n++) begin
      // R7: scramble unsampled configuration inputs while running
      mode_in = 2'(n + m + 1); async_div_in = 7'(n * 37 + 5); sync_div_in = 15'(n * 91 + 3);
      @(negedge clk);
      f  = n / (a + 1);
      ft = ((n - 1) % (a + 1)) == a;
      if (m == 0) begin
        exp_ss = s - (f % (s + 1));
        st = ft && (f % (s + 1) == 0) && f > 0;
      end else begin
        exp_ss = (64'hFFFF_FFFF - f) & 64'hFFFF_FFFF;
        st = (m != 1) && ft && (f % (1 << MB) == 0) && f > 0;
      end
      if (n == 1) check("R8 start value", subsec_count, (a == 0) ? ((m == 0) ? ((s == 0) ? 0 : s - 1) : 64'hFFFF_FFFE) : ld);
      check("R2 fast tick", fast_tick, ft);
      check(m == 0 ? "R3 cal count" : (m == 1 ? "R5 bin count" : "R6 mix count"), subsec_count, exp_ss);
      check(m == 0 ? "R4 cal sec" : (m == 1 ? "R5 bin sec" : "R6 mix sec"), sec_tick, st);
    end
  endtask

  initial begin
    int n;
    int first_fast;
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset fast", fast_tick, 0);
    check("R1 reset sec", sec_tick, 0);
    check("R1 reset count", subsec_count, 255);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset count", subsec_count, 255);
    n = 1; first_fast = 0;
    while (!sec_tick && n < 40000) begin
      if (fast_tick && first_fast == 0) first_fast = n;
      @(negedge clk);
      n++;
    end
    check("R9 first fast tick", first_fast, 128);
    check("R9 first second tick", n, 32768);

    for (int ai = 0; ai < 4; ai++) begin
      for (int si = 0; si < 4; si++) begin
        for (int m = 0; m < 4; m++) begin
          int a, s, span;
          a = (ai == 3) ? 4 : ai;
          s = (si == 3) ? 6 : ((si == 2) ? 3 : si);
          span = ((s + 1) > (1 << MB)) ? (s + 1) : (1 << MB);
          run_cfg(a, s, m, (a + 1) * span * 2 + 6);
        end
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule